// File: doc/BRIEF.md
# USB Host Controller Command Register Slice

This block is the command portion of a USB host controller's operational register set. Software writes a 32-bit word. Some bits start long-running operations carried out by engines elsewhere in the controller: a state save, a state restore, a full controller reset and a light controller reset. Other bits enable the delivery of interrupts and of out-of-band system error signalling. The operation bits do not hold what software wrote. Each one reads back as an in-progress flag. The flag rises on the clock edge that takes the write and falls on the edge that samples the matching engine's single-cycle done pulse.

Only one operation may be in progress at a time. A request that arrives while another operation is busy is dropped. So is a write that asks for more than one operation at once. Either case sets a sticky conflict flag. A full reset is accepted only while the controller reports itself halted. A full reset asked for while running is dropped and flagged for one cycle. An accepted full reset also returns both enables to 0. While it is in progress, writes to the enables have no effect.

Top module: `hc_cmd_reg`

## Requirements
- R1: After rst_ni is asserted, rd_data_o is 0 and every output flag is 0.
- R2: Writing 1 to bit 9 starts a restore. Bit 9 and restore_busy_o read 1 from the cycle after the write. They return to 0 on the clock edge that samples restore_done_i high. A done pulse while idle has no effect.
- R3: Writing 1 to bit 8 starts a save. Bit 8 and save_busy_o follow the same rise and fall rule, using save_done_i.
- R4: While halted_i is 1, writing 1 to bit 1 starts a full reset. Bit 1 and full_rst_o read 1 until the edge that samples full_rst_done_i high. Writing 0 to bit 1 meanwhile does not end it.
- R5: A full reset request written while halted_i is 0 is ignored: bit 1 stays 0. illegal_cmd_o is 1 for exactly the cycle after that write.
- R6: With LIGHT_RST_EN=1, bit 7 starts a light reset. Bit 7 and light_rst_o read 1 until light_rst_done_i is sampled high. With LIGHT_RST_EN=0, bit 7 always reads 0 and light_rst_o stays 0.
- R7: A request written while any operation is busy is ignored, and so is a write with more than one of bits 9, 8, 7 and 1 set. Either one sets op_conflict_o. op_conflict_o stays 1 until a full reset is accepted.
- R8: Bit 2 is the interrupt enable. irq_o is 1 exactly when bit 2 reads 1 and at least one bit of intr_req_i is 1.
- R9: Bit 3 is the error enable. oob_err_o is 1 exactly when bit 3 reads 1 and sys_err_i is 1. It drops once sys_err_i is cleared.
- R10: An accepted full reset clears bits 2 and 3, whatever the same write carries. Writes to bits 2 and 3 are ignored while the full reset is in progress.
- R11: Bits 31 to 10, bits 6 to 4 and bit 0 always read 0, even after 1s are written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Register read value |
| halted_i | input | 1 | Controller halted status |
| sys_err_i | input | 1 | Latched host system error status |
| intr_req_i | input | NUM_INTR | Interrupter requests |
| save_busy_o | output | 1 | Save in progress / save engine request |
| restore_busy_o | output | 1 | Restore in progress / restore engine request |
| full_rst_o | output | 1 | Full reset in progress / reset engine request |
| light_rst_o | output | 1 | Light reset in progress / light reset engine request |
| save_done_i | input | 1 | Save engine done pulse |
| restore_done_i | input | 1 | Restore engine done pulse |
| full_rst_done_i | input | 1 | Full reset engine done pulse |
| light_rst_done_i | input | 1 | Light reset engine done pulse |
| illegal_cmd_o | output | 1 | One-cycle flag: full reset requested while running |
| op_conflict_o | output | 1 | Sticky flag: overlapping or multiple requests |
| irq_o | output | 1 | Gated host interrupt |
| oob_err_o | output | 1 | Out-of-band system error signal |

## Verification
Each operation is first started alone and finished by its done pulse. This separates the immediate rise of a flag from its fall on completion. Done pulses sent while idle show they are ignored. Writes with two request bits set, and requests sent during a busy save, show that the exclusion logic drops the request and does not queue it. Full reset is tried with halted_i low and then high, which separates the illegal path from the accepted one. The enable bits are written before, during and after that reset. Toggling intr_req_i and sys_err_i with the enables on and off shows that the gating depends on both conditions together. A second instance built without light reset confirms that bit 7 stays 0 throughout.

// File: rtl/hc_cmd_pkg.sv
package hc_cmd_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned NUM_OPS = 4;

  // register bit positions seen by software
  localparam int unsigned BIT_FULL_RST  = 1;
  localparam int unsigned BIT_INT_EN    = 2;
  localparam int unsigned BIT_ERR_EN    = 3;
  localparam int unsigned BIT_LIGHT_RST = 7;
  localparam int unsigned BIT_SAVE      = 8;
  localparam int unsigned BIT_RESTORE   = 9;

  typedef enum logic [1:0] {
    OP_FULL    = 2'd0,
    OP_LIGHT   = 2'd1,
    OP_SAVE    = 2'd2,
    OP_RESTORE = 2'd3
  } op_e;
endpackage

// File: rtl/hc_cmd_seq.sv
module hc_cmd_seq
  import hc_cmd_pkg::*;
#(
  parameter bit LIGHT_EN = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [NUM_OPS-1:0] req_i,
  input  logic               halted_i,
  input  logic [NUM_OPS-1:0] done_i,
  output logic [NUM_OPS-1:0] busy_o,
  output logic               full_accept_o,
  output logic               illegal_o,
  output logic               conflict_o
);
  logic [NUM_OPS-1:0] busy_q, req_m, op_mask;
  logic any_busy, multi, has_req, conflict_set, full_bad, accept;
  logic illegal_q, conflict_q;

  always_comb begin
    op_mask = '1;
    op_mask[OP_LIGHT] = LIGHT_EN;
  end

  assign req_m        = req_i & op_mask;
  assign any_busy     = |busy_q;
  assign multi        = $countones(req_m) > 1;
  assign has_req      = wr_en_i && (|req_m);
  assign conflict_set = has_req && (any_busy || multi);
  assign full_bad     = has_req && !conflict_set && req_m[OP_FULL] && !halted_i;
  assign accept       = has_req && !conflict_set && !full_bad;
  assign full_accept_o = accept && req_m[OP_FULL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= '0;
      illegal_q  <= 1'b0;
      conflict_q <= 1'b0;
    end else begin
      for (int k = 0; k < NUM_OPS; k++) begin
        if (accept && req_m[k])  busy_q[k] <= 1'b1;
        else if (done_i[k])      busy_q[k] <= 1'b0;
      end
      illegal_q <= full_bad;
      if (conflict_set)       conflict_q <= 1'b1;
      else if (full_accept_o) conflict_q <= 1'b0;
    end
  end

  assign busy_o     = busy_q;
  assign illegal_o  = illegal_q;
  assign conflict_o = conflict_q;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_chk
    AST_RISE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_q[k]) |-> $past(wr_en_i && req_i[k])); // R2
    AST_FALL_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_q[k]) |-> $past(done_i[k])); // R3
  end

  AST_ONE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(busy_q)); // R7
  AST_FULL_WHEN_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q[OP_FULL]) |-> $past(halted_i)); // R5
endmodule

// File: rtl/hc_cmd_gate.sv
module hc_cmd_gate #(
  parameter int unsigned NUM_INTR = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                int_en_wr_i,
  input  logic                err_en_wr_i,
  input  logic                full_accept_i,
  input  logic                rst_busy_i,
  input  logic                sys_err_i,
  input  logic [NUM_INTR-1:0] intr_req_i,
  output logic                int_en_o,
  output logic                err_en_o,
  output logic                irq_o,
  output logic                oob_err_o
);
  logic int_en_q, err_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en_q <= 1'b0;
      err_en_q <= 1'b0;
    end else if (full_accept_i) begin
      int_en_q <= 1'b0;
      err_en_q <= 1'b0;
    end else if (wr_en_i && !rst_busy_i) begin
      int_en_q <= int_en_wr_i;
      err_en_q <= err_en_wr_i;
    end
  end

  assign int_en_o  = int_en_q;
  assign err_en_o  = err_en_q;
  assign irq_o     = int_en_q && (|intr_req_i);
  assign oob_err_o = err_en_q && sys_err_i;

  AST_EN_HELD_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_busy_i |-> (!int_en_q && !err_en_q)); // R10
endmodule

// File: rtl/hc_cmd_reg.sv
module hc_cmd_reg
  import hc_cmd_pkg::*;
#(
  parameter int unsigned NUM_INTR     = 4,
  parameter bit          LIGHT_RST_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_data_i,
  output logic [REG_W-1:0]    rd_data_o,
  input  logic                halted_i,
  input  logic                sys_err_i,
  input  logic [NUM_INTR-1:0] intr_req_i,
  output logic                save_busy_o,
  output logic                restore_busy_o,
  output logic                full_rst_o,
  output logic                light_rst_o,
  input  logic                save_done_i,
  input  logic                restore_done_i,
  input  logic                full_rst_done_i,
  input  logic                light_rst_done_i,
  output logic                illegal_cmd_o,
  output logic                op_conflict_o,
  output logic                irq_o,
  output logic                oob_err_o
);
  logic [NUM_OPS-1:0] req, done, busy;
  logic full_accept, int_en, err_en;

  always_comb begin
    req = '0;
    req[OP_FULL]    = wr_data_i[BIT_FULL_RST];
    req[OP_LIGHT]   = wr_data_i[BIT_LIGHT_RST];
    req[OP_SAVE]    = wr_data_i[BIT_SAVE];
    req[OP_RESTORE] = wr_data_i[BIT_RESTORE];
    done = '0;
    done[OP_FULL]    = full_rst_done_i;
    done[OP_LIGHT]   = light_rst_done_i;
    done[OP_SAVE]    = save_done_i;
    done[OP_RESTORE] = restore_done_i;
  end

  hc_cmd_seq #(.LIGHT_EN(LIGHT_RST_EN)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .req_i         (req),
    .halted_i      (halted_i),
    .done_i        (done),
    .busy_o        (busy),
    .full_accept_o (full_accept),
    .illegal_o     (illegal_cmd_o),
    .conflict_o    (op_conflict_o)
  );

  hc_cmd_gate #(.NUM_INTR(NUM_INTR)) u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .int_en_wr_i   (wr_data_i[BIT_INT_EN]),
    .err_en_wr_i   (wr_data_i[BIT_ERR_EN]),
    .full_accept_i (full_accept),
    .rst_busy_i    (busy[OP_FULL]),
    .sys_err_i     (sys_err_i),
    .intr_req_i    (intr_req_i),
    .int_en_o      (int_en),
    .err_en_o      (err_en),
    .irq_o         (irq_o),
    .oob_err_o     (oob_err_o)
  );

  always_comb begin
    rd_data_o = '0;
    rd_data_o[BIT_FULL_RST]  = busy[OP_FULL];
    rd_data_o[BIT_INT_EN]    = int_en;
    rd_data_o[BIT_ERR_EN]    = err_en;
    rd_data_o[BIT_LIGHT_RST] = busy[OP_LIGHT];
    rd_data_o[BIT_SAVE]      = busy[OP_SAVE];
    rd_data_o[BIT_RESTORE]   = busy[OP_RESTORE];
  end

  assign save_busy_o    = busy[OP_SAVE];
  assign restore_busy_o = busy[OP_RESTORE];
  assign full_rst_o     = busy[OP_FULL];
  assign light_rst_o    = busy[OP_LIGHT];
endmodule

// File: tb/hc_cmd_reg_tb_top.sv
module hc_cmd_reg_tb_top;
  localparam int NI = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, halted = 1'b1, sys_err = 1'b0;
  logic [31:0] wr_data = '0;
  logic [NI-1:0] intr_req = '0;
  logic save_done = 1'b0, restore_done = 1'b0, full_done = 1'b0, light_done = 1'b0;
  logic [31:0] rd, rd_nl;
  logic save_b, rest_b, full_b, light_b, ill, cf, irq, oob;
  logic save_b2, rest_b2, full_b2, light_b2, ill2, cf2, irq2, oob2;

  always #4 clk = ~clk; // 125 MHz

  hc_cmd_reg #(.NUM_INTR(NI), .LIGHT_RST_EN(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd),
    .halted_i(halted), .sys_err_i(sys_err), .intr_req_i(intr_req),
    .save_busy_o(save_b), .restore_busy_o(rest_b), .full_rst_o(full_b), .light_rst_o(light_b),
    .save_done_i(save_done), .restore_done_i(restore_done), .full_rst_done_i(full_done),
    .light_rst_done_i(light_done), .illegal_cmd_o(ill), .op_conflict_o(cf),
    .irq_o(irq), .oob_err_o(oob));

  hc_cmd_reg #(.NUM_INTR(NI), .LIGHT_RST_EN(1'b0)) dut_nolr_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_nl),
    .halted_i(halted), .sys_err_i(sys_err), .intr_req_i(intr_req),
    .save_busy_o(save_b2), .restore_busy_o(rest_b2), .full_rst_o(full_b2), .light_rst_o(light_b2),
    .save_done_i(save_done), .restore_done_i(restore_done), .full_rst_done_i(full_done),
    .light_rst_done_i(light_done), .illegal_cmd_o(ill2), .op_conflict_o(cf2),
    .irq_o(irq2), .oob_err_o(oob2));

  typedef struct {
    logic [31:0] rd;
    logic [7:0]  fl; // {irq,oob,conflict,illegal,light,full,save,restore}
    string       rq;
  } exp_t;
  exp_t q[$];

  int n_checks = 0, n_fail = 0;
  bit done_flag = 1'b0;

  // reference state; busy order {restore,save,light,full}
  logic [3:0] m_busy = '0;
  logic m_ie = 0, m_ee = 0, m_cf = 0, m_ill = 0;

  task automatic step(input logic we, input logic [31:0] wd, input logic hlt, input logic se,
                      input logic [NI-1:0] ir, input logic [3:0] dn, input string rq);
    exp_t e;
    logic any_b, pre_full, acc_full;
    logic [3:0] rqv;
    int cnt;
    @(negedge clk); #1;
    wr_en = we; wr_data = wd; halted = hlt; sys_err = se; intr_req = ir;
    {restore_done, save_done, light_done, full_done} = dn;
    any_b = |m_busy; pre_full = m_busy[0]; acc_full = 0;
    rqv = we ? {wd[9], wd[8], wd[7], wd[1]} : 4'b0;
    cnt = $countones(rqv);
    m_ill = 0;
    m_busy = m_busy & ~dn;
    if (cnt > 0) begin
      if (any_b || cnt > 1) m_cf = 1;
      else if (rqv[0] && !hlt) m_ill = 1;
      else begin
        m_busy = m_busy | rqv;
        if (rqv[0]) begin acc_full = 1; m_cf = 0; m_ie = 0; m_ee = 0; end
      end
    end
    if (we && !pre_full && !acc_full) begin m_ie = wd[2]; m_ee = wd[3]; end
    e.rd = '0;
    e.rd[9] = m_busy[3]; e.rd[8] = m_busy[2]; e.rd[7] = m_busy[1];
    e.rd[3] = m_ee; e.rd[2] = m_ie; e.rd[1] = m_busy[0];
    e.fl = {m_ie && (|ir), m_ee && se, m_cf, m_ill, m_busy[1], m_busy[0], m_busy[2], m_busy[3]};
    e.rq = rq;
    @(posedge clk); #1;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = {irq, oob, cf, ill, light_b, full_b, save_b, rest_b};
      n_checks++;
      if (rd !== it.rd || act !== it.fl) begin
        n_fail++;
        $display("FAIL %s: rd=%h flags=%b expected rd=%h flags=%b", it.rq, rd, act, it.rd, it.fl);
      end
      n_checks++; // R6 without light reset capability
      if (rd_nl[7] !== 1'b0 || light_b2 !== 1'b0) begin
        n_fail++;
        $display("FAIL R6: no-light instance bit7=%b light=%b expected 0 0", rd_nl[7], light_b2);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    n_checks++; // R1 during reset
    if (rd !== 32'h0 || {irq, oob, cf, ill, light_b, full_b, save_b, rest_b} !== 8'h0) begin
      n_fail++;
      $display("FAIL R1: rd=%h expected 0", rd);
    end
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 1, 0, 0, 0, "R1 idle after reset");
    // reserved bits
    step(1, 32'hFFFF_FC71, 1, 0, 0, 0, "R11 reserved write");
    step(0, 0, 1, 0, 4'hF, 0, "R11 reserved readback");
    // interrupt gating
    step(1, 32'h4, 1, 0, 0, 0, "R8 enable no request");
    step(0, 0, 1, 0, 4'b0010, 0, "R8 enable with request");
    step(0, 0, 1, 0, 4'b1000, 0, "R8 other request");
    step(1, 32'h0, 1, 0, 4'b1000, 0, "R8 disabled with request");
    // error gating
    step(1, 32'h8, 1, 1, 0, 0, "R9 enable and error");
    step(0, 0, 1, 0, 0, 0, "R9 error cleared");
    step(1, 32'h0, 1, 1, 0, 0, "R9 disabled with error");
    // save / restore
    step(0, 0, 1, 0, 0, 4'b0100, "R3 stray done idle");
    step(1, 32'h100, 1, 0, 0, 0, "R3 save start");
    step(0, 0, 1, 0, 0, 0, "R3 save held");
    step(0, 0, 1, 0, 0, 4'b0100, "R3 save done");
    step(0, 0, 1, 0, 0, 0, "R3 save idle");
    step(1, 32'h200, 1, 0, 0, 0, "R2 restore start");
    step(1, 32'h0, 1, 0, 0, 0, "R2 zero write no abort");
    step(0, 0, 1, 0, 0, 4'b0100, "R2 wrong done");
    step(0, 0, 1, 0, 0, 4'b1000, "R2 restore done");
    // exclusivity
    step(1, 32'h300, 1, 0, 0, 0, "R7 double request");
    step(1, 32'h100, 1, 0, 0, 0, "R7 save after conflict");
    step(1, 32'h200, 1, 0, 0, 0, "R7 restore while save busy");
    step(0, 0, 1, 0, 0, 4'b0100, "R7 save done");
    // illegal full reset
    step(1, 32'h2, 0, 0, 0, 0, "R5 reset while running");
    step(0, 0, 0, 0, 0, 0, "R5 illegal drops");
    // full reset
    step(1, 32'hC, 1, 0, 0, 0, "R10 enables set");
    step(1, 32'hE, 1, 1, 4'h1, 0, "R4 full reset accepted");
    step(1, 32'hC, 1, 1, 4'h1, 0, "R10 enable write during reset");
    step(1, 32'h0, 1, 0, 0, 0, "R4 zero write no abort");
    step(0, 0, 1, 0, 0, 4'b0001, "R4 reset done");
    step(1, 32'hC, 1, 1, 4'h2, 0, "R10 enables after reset");
    // light reset
    step(1, 32'h80, 1, 0, 0, 0, "R6 light start");
    step(0, 0, 1, 0, 0, 0, "R6 light held");
    step(0, 0, 1, 0, 0, 4'b0010, "R6 light done");
    step(0, 0, 1, 0, 0, 0, "R6 idle");
    repeat (3) @(negedge clk);
    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule